// File: doc/BRIEF.md
# Dual-Rail Line Transmit Input Interface

This block sits between terminal equipment and the pulse shaper of a 2.048 Mbit/s line transmitter. Terminal equipment supplies a positive and a negative data rail, and optionally a transmit clock. The block judges by itself whether that clock is running. With a running clock it captures the rails as NRZ data on each falling clock edge. With an idle-high clock it treats each rail as return-to-zero data and takes a rising rail edge as a bit. Every captured mark becomes a half-bit request pulse on the matching polarity output, for the shaper downstream.

All pins pass through two-stage synchronizers into an oversampling system clock domain. `UI_CYC` system cycles make one unit interval. The block also decides when the line driver must be shut off. It does so when both data rails sit high, which is also the pulled-up floating state, and when the transmit clock is held low. It handles the diagnostic selects too. Remote loopback swaps in the received rails as the transmit source. Local loopback is forwarded to the receive side. When both selects are raised together, the block enters a test mode with all outputs disabled.

Top module: `tx_in_iface`

## Requirements
- R1: After reset, both mark outputs and `err_o` are 0, `clocked_o` is 0, and `drv_en_o` and `out_en_o` are 1.
- R2: `clocked_o` rises after any edge of `tx_clk_i`. It falls once no edge has been seen for `4*UI_CYC` system cycles.
- R3: While `clocked_o` is 1, the rails are sampled at each falling edge of `tx_clk_i`. Rail value {pos,neg} = 10 gives a positive mark, 01 gives a negative mark, and 00 gives no mark.
- R4: While `clocked_o` is 0, a rising edge on a rail is a bit. The rail values {pos,neg} in that cycle choose the mark with the same coding as R3.
- R5: Every mark is a pulse of exactly `UI_CYC/2` system cycles. `mark_pos_o` and `mark_neg_o` are never high together.
- R6: A bit whose rails are both 1 produces no mark. If the driver is not shut off at that moment, `err_o` goes high for exactly one cycle.
- R7: When both transmit rails stay high for `2*UI_CYC` consecutive cycles, `drv_en_o` drops to 0 and the marks stay low. Both recover once either rail returns to 0.
- R8: When `tx_clk_i` is held low for `4*UI_CYC` cycles, `drv_en_o` is 0 and no mark appears, even while RZ data is still applied.
- R9: With `rloop_i`=1 and `lloop_i`=0, the receive rails `rx_pos_i` and `rx_neg_i` drive the marks as return-to-zero data. The transmit rails and the transmit clock are then ignored, including both shutdown conditions, and they raise no `err_o`.
- R10: With `lloop_i`=1 and `rloop_i`=1, `out_en_o` and `drv_en_o` are 0, no mark or `err_o` appears, and `loc_lpbk_o` is 0.
- R11: With `lloop_i`=1 and `rloop_i`=0, `loc_lpbk_o` is 1 and transmit marks are produced normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_clk_i | input | 1 | Transmit clock from terminal equipment; idle high when absent |
| tx_pos_i | input | 1 | Positive data rail from terminal equipment |
| tx_neg_i | input | 1 | Negative data rail from terminal equipment |
| rx_pos_i | input | 1 | Received positive rail, used in remote loopback |
| rx_neg_i | input | 1 | Received negative rail, used in remote loopback |
| lloop_i | input | 1 | Local loopback select |
| rloop_i | input | 1 | Remote loopback select |
| mark_pos_o | output | 1 | Positive mark request, half-bit pulse |
| mark_neg_o | output | 1 | Negative mark request, half-bit pulse |
| err_o | output | 1 | One-cycle flag for a bit with both rails set |
| drv_en_o | output | 1 | Line driver enable; 0 during shutdown or test mode |
| out_en_o | output | 1 | Output enable; 0 in test mode |
| clocked_o | output | 1 | 1 while transmit clock activity is seen |
| loc_lpbk_o | output | 1 | Local loopback request to the receive path |

## Verification
A wrong mode decision shows on `clocked_o` and in the mark stream. A corrupt idle timer either misses the `4*UI_CYC` timeout, or it makes NRZ data take the edge-capture path, so marks are lost or doubled within one or two bit periods. A wrong polarity or pulse-length register appears on the very next mark. That mark starts three system cycles after the sampling edge reaches the pins, and it has the wrong polarity or a length other than `UI_CYC/2`. A shutdown counter that is stuck or overflows shows as `drv_en_o` dropping after a single both-ones bit, or staying high through a long hold of both rails.

// File: rtl/tx_in_pkg.sv
package tx_in_pkg;
  typedef enum logic [1:0] {
    MK_NONE = 2'b00,
    MK_NEG  = 2'b01,
    MK_POS  = 2'b10,
    MK_BOTH = 2'b11
  } rail_t;
endpackage

// File: rtl/tx_in_sync.sv
module tx_in_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tx_in_clk_mon.sv
module tx_in_clk_mon #(
  parameter int IDLE_LIM = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_s_i,
  output logic clocked_o,
  output logic fall_o,
  output logic idle_low_o
);
  localparam int CW = $clog2(IDLE_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIM);

  logic          tclk_q;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tclk_q   <= 1'b1;
      idle_cnt <= LIM;
    end else begin
      tclk_q <= tclk_s_i;
      if (tclk_s_i != tclk_q)   idle_cnt <= '0;
      else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign clocked_o  = (idle_cnt != LIM);
  assign fall_o     = tclk_q & ~tclk_s_i;
  assign idle_low_o = ~clocked_o & ~tclk_s_i;
endmodule

// File: rtl/tx_in_stuck_det.sv
module tx_in_stuck_det #(
  parameter int STUCK_LIM = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic both_i,
  output logic stuck_o
);
  localparam int CW = $clog2(STUCK_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(STUCK_LIM);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (!both_i)    cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign stuck_o = (cnt == LIM);
endmodule

// File: rtl/tx_in_mark_gen.sv
module tx_in_mark_gen
  import tx_in_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ev_i,
  input  rail_t rail_i,
  input  logic  block_i,
  output logic  pos_o,
  output logic  neg_o,
  output logic  err_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LEN = CW'(HALF);

  logic [CW-1:0] cnt;
  rail_t         pol;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      pol   <= MK_NONE;
      err_q <= 1'b0;
    end else begin
      err_q <= ev_i && (rail_i == MK_BOTH) && !block_i;
      if (ev_i && (rail_i == MK_POS || rail_i == MK_NEG)) begin
        cnt <= LEN;
        pol <= rail_i;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign pos_o = (cnt != '0) && (pol == MK_POS);
  assign neg_o = (cnt != '0) && (pol == MK_NEG);
  assign err_o = err_q;
endmodule

// File: rtl/tx_in_iface.sv
module tx_in_iface
  import tx_in_pkg::*;
#(
  parameter int UI_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_clk_i,
  input  logic tx_pos_i,
  input  logic tx_neg_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic lloop_i,
  input  logic rloop_i,
  output logic mark_pos_o,
  output logic mark_neg_o,
  output logic err_o,
  output logic drv_en_o,
  output logic out_en_o,
  output logic clocked_o,
  output logic loc_lpbk_o
);
  localparam int HALF      = UI_CYC / 2;
  localparam int IDLE_LIM  = 4 * UI_CYC;
  localparam int STUCK_LIM = 2 * UI_CYC;

  logic       clk_s;
  logic [5:0] bus_s;
  logic [1:0] tx_s, rx_s;
  logic       lloop_s, rloop_s;

  tx_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk_i, .rst_ni, .d_i(tx_clk_i), .q_o(clk_s)
  );
  tx_in_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b0)) u_sync_bus (
    .clk_i, .rst_ni,
    .d_i({lloop_i, rloop_i, rx_pos_i, rx_neg_i, tx_pos_i, tx_neg_i}),
    .q_o(bus_s)
  );
  assign {lloop_s, rloop_s, rx_s, tx_s} = bus_s;

  logic test_mode, rem_lb;
  assign test_mode = lloop_s & rloop_s;
  assign rem_lb    = rloop_s & ~lloop_s;

  logic clocked, tfall, idle_low;
  tx_in_clk_mon #(.IDLE_LIM(IDLE_LIM)) u_clk_mon (
    .clk_i, .rst_ni, .tclk_s_i(clk_s),
    .clocked_o(clocked), .fall_o(tfall), .idle_low_o(idle_low)
  );

  logic stuck;
  tx_in_stuck_det #(.STUCK_LIM(STUCK_LIM)) u_stuck (
    .clk_i, .rst_ni, .both_i(&tx_s), .stuck_o(stuck)
  );

  // remote loopback: received rails replace terminal rails, always RZ capture
  logic [1:0] src, src_q, rise;
  logic       ev, shutdown;
  assign src  = rem_lb ? rx_s : tx_s;
  assign rise = src & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 2'b00;
    else         src_q <= src;
  end

  assign ev       = (clocked && !rem_lb) ? tfall : |rise;
  assign shutdown = ~rem_lb & (stuck | idle_low);

  logic raw_pos, raw_neg, raw_err;
  tx_in_mark_gen #(.HALF(HALF)) u_mark (
    .clk_i, .rst_ni, .ev_i(ev), .rail_i(rail_t'(src)),
    .block_i(shutdown | test_mode),
    .pos_o(raw_pos), .neg_o(raw_neg), .err_o(raw_err)
  );

  assign out_en_o   = ~test_mode;
  assign drv_en_o   = ~shutdown & ~test_mode;
  assign mark_pos_o = raw_pos & drv_en_o;
  assign mark_neg_o = raw_neg & drv_en_o;
  assign err_o      = raw_err & out_en_o;
  assign clocked_o  = clocked;
  assign loc_lpbk_o = lloop_s & ~rloop_s;
endmodule

// File: rtl/tx_in_iface_chk.sv
module tx_in_iface_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mark_pos_o,
  input logic mark_neg_o,
  input logic err_o,
  input logic drv_en_o,
  input logic out_en_o,
  input logic clocked_o,
  input logic clk_s_i
);
  AST_MARK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_pos_o && mark_neg_o)); // R5

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mark_pos_o) |=> (mark_pos_o || !drv_en_o)); // R5

  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R6

  AST_SD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> (!mark_pos_o && !mark_neg_o)); // R7

  AST_TEST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> (!mark_pos_o && !mark_neg_o && !err_o && !drv_en_o)); // R10

  AST_CLK_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clocked_o) |-> ($past(clk_s_i) != $past(clk_s_i, 2))); // R2
endmodule

bind tx_in_iface tx_in_iface_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mark_pos_o (mark_pos_o),
  .mark_neg_o (mark_neg_o),
  .err_o      (err_o),
  .drv_en_o   (drv_en_o),
  .out_en_o   (out_en_o),
  .clocked_o  (clocked_o),
  .clk_s_i    (clk_s)
);

// File: tb/tx_in_iface_tb.sv
module tx_in_iface_tb;
  localparam int UI   = 16;
  localparam int HALF = UI / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_clk = 1'b1, tx_pos = 1'b0, tx_neg = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, lloop = 1'b0, rloop = 1'b0;
  logic mark_pos, mark_neg, err, drv_en, out_en, clocked, loc_lpbk;

  int n_chk = 0, n_bad = 0;
  int obs_q[$], exp_q[$];
  int width_bad = 0, err_cnt = 0, pos_run = 0, neg_run = 0;
  int s;

  always #2 clk = ~clk;

  tx_in_iface #(.UI_CYC(UI)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_clk_i(tx_clk), .tx_pos_i(tx_pos),
    .tx_neg_i(tx_neg), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg),
    .lloop_i(lloop), .rloop_i(rloop), .mark_pos_o(mark_pos),
    .mark_neg_o(mark_neg), .err_o(err), .drv_en_o(drv_en),
    .out_en_o(out_en), .clocked_o(clocked), .loc_lpbk_o(loc_lpbk)
  );

  // mark stream monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (err) err_cnt++;
      if (mark_pos) pos_run++;
      else if (pos_run > 0) begin
        obs_q.push_back(1);
        if (pos_run != HALF) width_bad++;
        pos_run = 0;
      end
      if (mark_neg) neg_run++;
      else if (neg_run > 0) begin
        obs_q.push_back(-1);
        if (neg_run != HALF) width_bad++;
        neg_run = 0;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sym_mark(input int sy);
    return (sy == 1) ? 1 : (sy == 2) ? -1 : 0;
  endfunction

  function automatic logic [1:0] sym_rails(input int sy);
    return (sy == 1) ? 2'b10 : (sy == 2) ? 2'b01 : (sy == 3) ? 2'b11 : 2'b00;
  endfunction

  task automatic clear_obs();
    obs_q.delete(); exp_q.delete();
    width_bad = 0; err_cnt = 0;
  endtask

  task automatic expect_sym(input int sy);
    if (sym_mark(sy) != 0) exp_q.push_back(sym_mark(sy));
  endtask

  task automatic bit_clocked(input int sy);
    tx_clk = 1'b1;
    {tx_pos, tx_neg} = sym_rails(sy);
    tick(HALF);
    tx_clk = 1'b0;
    tick(HALF);
    expect_sym(sy);
  endtask

  task automatic bit_rz_tx(input int sy);
    {tx_pos, tx_neg} = sym_rails(sy);
    tick(HALF);
    {tx_pos, tx_neg} = 2'b00;
    tick(HALF);
    expect_sym(sy);
  endtask

  task automatic bit_rz_rx(input int sy);
    {rx_pos, rx_neg} = sym_rails(sy);
    tick(HALF);
    {rx_pos, rx_neg} = 2'b00;
    tick(HALF);
    expect_sym(sy);
  endtask

  task automatic cmp_marks(input string req);
    int bad = -1;
    chk({req, " mark count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && obs_q[i] != exp_q[i]) bad = i;
    chk({req, " first mismatching mark index"}, bad, -1);
    chk({req, " R5 pulse width errors"}, width_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 mark_pos", mark_pos, 0);
    chk("R1 mark_neg", mark_neg, 0);
    chk("R1 err", err, 0);
    chk("R1 clocked", clocked, 0);
    chk("R1 drv_en", drv_en, 1);
    chk("R1 out_en", out_en, 1);

    // R3 clocked NRZ with random symbols, plus one both-ones bit (R6)
    clear_obs();
    bit_clocked(0); bit_clocked(0);
    chk("R2 clocked after edges", clocked, 1);
    for (int i = 0; i < 40; i++) bit_clocked($urandom_range(2, 0));
    bit_clocked(3);
    for (int i = 0; i < 3; i++) bit_clocked($urandom_range(2, 0));
    bit_clocked(0);
    tx_clk = 1'b1; {tx_pos, tx_neg} = 2'b00;
    tick(2 * UI);
    cmp_marks("R3 clocked");
    chk("R6 clocked both-ones err pulses", err_cnt, 1);
    tick(4 * UI + 8);
    chk("R2 clockless after idle", clocked, 0);
    chk("R2 drv_en with idle-high clock", drv_en, 1);

    // R4 clockless RZ
    clear_obs();
    for (int i = 0; i < 40; i++) bit_rz_tx($urandom_range(2, 0));
    bit_rz_tx(1); bit_rz_tx(1); bit_rz_tx(2); bit_rz_tx(2);
    bit_rz_tx(3);
    bit_rz_tx(2);
    tick(UI);
    cmp_marks("R4 clockless");
    chk("R6 clockless both-ones err pulses", err_cnt, 1);
    chk("R4 mode stays clockless", clocked, 0);

    // R7 both rails held high
    clear_obs();
    {tx_pos, tx_neg} = 2'b11;
    tick(2 * UI + 8);
    chk("R7 drv_en while rails stuck", drv_en, 0);
    tick(UI);
    chk("R7 no marks while stuck", obs_q.size(), 0);
    {tx_pos, tx_neg} = 2'b00;
    tick(6);
    chk("R7 drv_en recovers", drv_en, 1);
    chk("R6 one err at stuck entry", err_cnt, 1);
    clear_obs();
    bit_rz_tx(1); bit_rz_tx(2);
    tick(UI);
    cmp_marks("R7 after release");

    // R8 transmit clock held low
    clear_obs();
    tx_clk = 1'b0;
    tick(4 * UI + 10);
    chk("R8 drv_en with clock low", drv_en, 0);
    chk("R8 clocked with clock low", clocked, 0);
    for (int i = 0; i < 6; i++) bit_rz_tx(1 + (i % 2));
    exp_q.delete();
    tick(UI);
    chk("R8 no marks with clock low", obs_q.size(), 0);
    tx_clk = 1'b1;
    tick(4 * UI + 10);
    chk("R8 drv_en after clock released high", drv_en, 1);

    // R9 remote loopback, terminal rails parked at both-ones
    clear_obs();
    rloop = 1'b1;
    tick(5);
    tx_clk = 1'b0;
    {tx_pos, tx_neg} = 2'b11;
    for (int i = 0; i < 24; i++) bit_rz_rx($urandom_range(2, 0));
    bit_rz_rx(3);
    chk("R9 drv_en ignores terminal shutdown pins", drv_en, 1);
    bit_rz_rx(1); bit_rz_rx(2);
    tick(UI);
    cmp_marks("R9 remote loopback");
    chk("R9 err pulses (one from received both-ones)", err_cnt, 1);
    chk("R9 loc_lpbk", loc_lpbk, 0);
    {tx_pos, tx_neg} = 2'b00;
    tx_clk = 1'b1;
    tick(5);
    rloop = 1'b0;
    tick(4 * UI + 10);

    // R10 test mode
    clear_obs();
    lloop = 1'b1; rloop = 1'b1;
    tick(5);
    chk("R10 out_en", out_en, 0);
    chk("R10 drv_en", drv_en, 0);
    chk("R10 loc_lpbk", loc_lpbk, 0);
    bit_rz_tx(1); bit_rz_tx(3); bit_rz_tx(2);
    exp_q.delete();
    tick(UI);
    chk("R10 no marks", obs_q.size(), 0);
    chk("R10 no err", err_cnt, 0);

    // R11 local loopback alone
    clear_obs();
    rloop = 1'b0;
    tick(5);
    chk("R11 loc_lpbk", loc_lpbk, 1);
    chk("R11 out_en", out_en, 1);
    bit_rz_tx(1); bit_rz_tx(2);
    tick(UI);
    cmp_marks("R11 local loopback");
    lloop = 1'b0;
    tick(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule